// File: doc/BRIEF.md
# Multi-Channel Timer Input Noise Filter

This block sits between up to four asynchronous timer input pins and the timer channels that consume them. Each pin is first brought into the domain of its channel through a two-flop synchronizer. The synchronized signal then reaches the channel either directly or through a stability filter, which lets a new level through only after it has been seen at two consecutive sampling points. Every channel advances only on cycles where its own operating-clock enable is high, so channels can sample at different effective rates from one system clock.

An 8-bit control register holds one filter-enable bit per channel. Software updates it through a whole-byte write or a single-bit write. A separate source-select input decides whether channel 1 conditions its own timer pin or a serial receive-data pin. A parameter removes channels 2 and 3 for smaller configurations.

Top module: `tinf_top`

## Requirements
- R1: With a channel's filter disabled, a pin level driven before operating edge 1 appears on that channel's `filtOut` after operating edge 3 (two synchronizer flops, then the output register). A pulse lasting w operating cycles gives an output pulse of exactly w cycles.
- R2: With a channel's filter enabled, the output takes a new level only once the synchronized input has shown that level at two consecutive operating edges. A level driven before edge 1 appears after edge 4. A one-cycle pulse is suppressed. A pulse of w ≥ 2 cycles gives an output pulse of w cycles.
- R3: While a channel's `opClkEn` bit is 0, its synchronizer, filter and output all hold, and `filtOut` for that channel does not change.
- R4: Reset clears the control register to 0x00 and every `filtOut` bit to 0. Register bit n (n = 0..3) enables filtering on channel n (1 = on). Bits 7..4 always read 0.
- R5: A byte write loads the register with `byteWrData` masked to the bits of the channels that exist. The new value shows on `ctrlRdData` after the next clock edge. A byte write wins over a bit write in the same cycle.
- R6: A bit write sets register bit `bitWrIdx` (3-bit index) to `bitWrData` and leaves every other bit unchanged. Indices 4 to 7 are ignored.
- R7: With `ch1SrcSel` = 0, channel 1 conditions `tmrPin[1]`. With `ch1SrcSel` = 1, it conditions `rxdPin`, and `tmrPin[1]` has no effect on channel 1.
- R8: With `NUM_CH` = 2, channels 2 and 3 are absent: their register bits read 0 whatever is written to them, and `filtOut[3:2]` stay 0.
- R9: A change of a filter-enable bit takes effect at the next operating edge. The output register keeps its value across the change, so toggling the enable with a steady input produces no output pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| byteWrEn | input | 1 | Whole-register write strobe |
| byteWrData | input | 8 | Data for the whole-register write |
| bitWrEn | input | 1 | Single-bit write strobe |
| bitWrIdx | input | 3 | Bit index for the single-bit write |
| bitWrData | input | 1 | Value for the single-bit write |
| ch1SrcSel | input | 1 | Channel 1 source: 0 = timer pin, 1 = receive-data pin |
| tmrPin | input | 4 | Asynchronous timer input pins, one per channel |
| rxdPin | input | 1 | Asynchronous serial receive-data pin |
| opClkEn | input | 4 | Per-channel operating-clock enable |
| ctrlRdData | output | 8 | Current control register value |
| filtOut | output | 4 | Conditioned input for each timer channel |

## Verification
Register writes show up on `ctrlRdData` one edge after the strobe. The bench drives each write at a falling edge and reads the result at the next falling edge. Pin changes reach `filtOut` three operating edges later with the filter off, and four with it on. The latency checks sample just before and just after that edge. The pulse sweeps count high output cycles over a window much longer than any latency, so the expected count (w, or 0 for a filtered one-cycle pulse) does not depend on alignment. Stall and enable-toggle checks sample on every cycle of the window, so a single-cycle glitch cannot be missed.

// File: rtl/tinf_pkg.sv
package tinf_pkg;
  localparam int CH_MAX = 4;
  localparam int REG_W  = 8;
  localparam int IDX_W  = 3;

  typedef struct packed {
    logic [CH_MAX-1:0] fltEn;
    logic              ch1FromRxd;
  } ctrlStrobes_t;
endpackage

// File: rtl/tinf_chan.sv
module tinf_chan #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic fltEn,
  input  logic pinIn,
  output logic filtOut
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   syncOut;
  logic                   prevQ;
  logic                   outQ;
  logic                   agree;

  assign syncOut = syncQ[SYNC_STAGES-1];
  assign agree   = (syncOut == prevQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
      outQ  <= 1'b0;
    end else if (tick) begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], pinIn};
      prevQ <= syncOut;
      if (!fltEn || agree) begin
        outQ <= syncOut;
      end
    end
  end

  assign filtOut = outQ;
endmodule

// File: rtl/tinf_datapath.sv
module tinf_datapath
  import tinf_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [CH_MAX-1:0] tmrPin,
  input  logic              rxdPin,
  input  logic [CH_MAX-1:0] opClkEn,
  output logic [CH_MAX-1:0] filtOut
);
  for (genvar g = 0; g < CH_MAX; g++) begin : gCh
    if (g < NUM_CH) begin : gLive
      logic rawIn;
      if (g == 1) begin : gMux
        assign rawIn = strobes.ch1FromRxd ? rxdPin : tmrPin[g];
      end else begin : gDirect
        assign rawIn = tmrPin[g];
      end
      tinf_chan #(.SYNC_STAGES(SYNC_STAGES)) uChan (
        .clk    (clk),
        .rstN   (rstN),
        .tick   (opClkEn[g]),
        .fltEn  (strobes.fltEn[g]),
        .pinIn  (rawIn),
        .filtOut(filtOut[g])
      );
    end else begin : gAbsent
      assign filtOut[g] = 1'b0;
    end
  end
endmodule

// File: rtl/tinf_ctrl.sv
module tinf_ctrl
  import tinf_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             byteWrEn,
  input  logic [REG_W-1:0] byteWrData,
  input  logic             bitWrEn,
  input  logic [IDX_W-1:0] bitWrIdx,
  input  logic             bitWrData,
  input  logic             ch1SrcSel,
  output logic [REG_W-1:0] ctrlRdData,
  output ctrlStrobes_t     strobes
);
  localparam logic [REG_W-1:0] VALID_MASK = REG_W'((1 << NUM_CH) - 1);

  logic [REG_W-1:0] regQ;
  logic [REG_W-1:0] bitSel;
  logic [REG_W-1:0] regNext;

  assign bitSel = VALID_MASK & (REG_W'(1) << bitWrIdx);

  always_comb begin
    regNext = regQ;
    if (byteWrEn) begin
      regNext = byteWrData & VALID_MASK;
    end else if (bitWrEn) begin
      regNext = (regQ & ~bitSel) | (bitWrData ? bitSel : '0);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regQ <= '0;
    else       regQ <= regNext;
  end

  assign ctrlRdData         = regQ;
  assign strobes.fltEn      = regQ[CH_MAX-1:0];
  assign strobes.ch1FromRxd = ch1SrcSel;
endmodule

// File: rtl/tinf_top.sv
module tinf_top
  import tinf_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       byteWrEn,
  input  logic [7:0] byteWrData,
  input  logic       bitWrEn,
  input  logic [2:0] bitWrIdx,
  input  logic       bitWrData,
  input  logic       ch1SrcSel,
  input  logic [3:0] tmrPin,
  input  logic       rxdPin,
  input  logic [3:0] opClkEn,
  output logic [7:0] ctrlRdData,
  output logic [3:0] filtOut
);
  ctrlStrobes_t strobes;

  tinf_ctrl #(.NUM_CH(NUM_CH)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .byteWrEn  (byteWrEn),
    .byteWrData(byteWrData),
    .bitWrEn   (bitWrEn),
    .bitWrIdx  (bitWrIdx),
    .bitWrData (bitWrData),
    .ch1SrcSel (ch1SrcSel),
    .ctrlRdData(ctrlRdData),
    .strobes   (strobes)
  );

  tinf_datapath #(.NUM_CH(NUM_CH), .SYNC_STAGES(SYNC_STAGES)) uPath (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .tmrPin (tmrPin),
    .rxdPin (rxdPin),
    .opClkEn(opClkEn),
    .filtOut(filtOut)
  );
endmodule

// File: rtl/tinf_checker.sv
module tinf_checker #(
  parameter int NUM_CH = 4
) (
  input logic       clk,
  input logic       rstN,
  input logic       byteWrEn,
  input logic [7:0] byteWrData,
  input logic       bitWrEn,
  input logic [2:0] bitWrIdx,
  input logic       bitWrData,
  input logic [3:0] opClkEn,
  input logic [7:0] ctrlRdData,
  input logic [3:0] filtOut
);
  localparam logic [7:0] VALID_MASK = 8'((1 << NUM_CH) - 1);

  logic [7:0] bitMask;
  logic       bitLive;
  assign bitMask = 8'(8'd1 << bitWrIdx);
  assign bitLive = |(bitMask & VALID_MASK);

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlRdData & ~VALID_MASK) == 8'h00);  // R4

  AST_BYTE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    byteWrEn |=> ctrlRdData == ($past(byteWrData) & VALID_MASK));  // R5

  AST_BIT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (bitWrEn && !byteWrEn && bitLive) |=>
      ((ctrlRdData & $past(bitMask)) == ($past(bitWrData) ? $past(bitMask) : 8'h00)) &&
      ((ctrlRdData & ~$past(bitMask)) == ($past(ctrlRdData) & ~$past(bitMask))));  // R6

  AST_BIT_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (bitWrEn && !byteWrEn && !bitLive) |=> $stable(ctrlRdData));  // R6

  for (genvar g = 0; g < 4; g++) begin : gOut
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      !opClkEn[g] |=> $stable(filtOut[g]));  // R3
    if (g >= NUM_CH) begin : gGone
      AST_ABSENT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
        filtOut[g] == 1'b0);  // R8
    end
  end
endmodule

bind tinf_top tinf_checker #(.NUM_CH(NUM_CH)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .byteWrEn  (byteWrEn),
  .byteWrData(byteWrData),
  .bitWrEn   (bitWrEn),
  .bitWrIdx  (bitWrIdx),
  .bitWrData (bitWrData),
  .opClkEn   (opClkEn),
  .ctrlRdData(ctrlRdData),
  .filtOut   (filtOut)
);

// File: tb/tb_tinf_top.sv
module tb_tinf_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       byteWrEn = 1'b0;
  logic [7:0] byteWrData = 8'h00;
  logic       bitWrEn = 1'b0;
  logic [2:0] bitWrIdx = 3'd0;
  logic       bitWrData = 1'b0;
  logic       ch1SrcSel = 1'b0;
  logic [3:0] tmrPin = 4'h0;
  logic       rxdPin = 1'b0;
  logic [3:0] opClkEn = 4'hF;
  logic [7:0] ctrlRdData, ctrlRdSmall;
  logic [3:0] filtOut, filtOutSmall;

  int  checkCnt = 0;
  int  failCnt  = 0;
  bit  done     = 1'b0;
  bit  smallLeak = 1'b0;

  always #2 clk = ~clk;

  tinf_top #(.NUM_CH(4)) dut (
    .clk(clk), .rstN(rstN), .byteWrEn(byteWrEn), .byteWrData(byteWrData),
    .bitWrEn(bitWrEn), .bitWrIdx(bitWrIdx), .bitWrData(bitWrData),
    .ch1SrcSel(ch1SrcSel), .tmrPin(tmrPin), .rxdPin(rxdPin), .opClkEn(opClkEn),
    .ctrlRdData(ctrlRdData), .filtOut(filtOut)
  );

  tinf_top #(.NUM_CH(2)) dutSmall (
    .clk(clk), .rstN(rstN), .byteWrEn(byteWrEn), .byteWrData(byteWrData),
    .bitWrEn(bitWrEn), .bitWrIdx(bitWrIdx), .bitWrData(bitWrData),
    .ch1SrcSel(ch1SrcSel), .tmrPin(tmrPin), .rxdPin(rxdPin), .opClkEn(opClkEn),
    .ctrlRdData(ctrlRdSmall), .filtOut(filtOutSmall)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (filtOutSmall[3:2] != 2'b00) smallLeak = 1'b1;
  endtask

  task automatic wrByte(input logic [7:0] v);
    byteWrEn = 1'b1; byteWrData = v;
    tick();
    byteWrEn = 1'b0;
  endtask

  task automatic wrBit(input int idx, input bit d);
    bitWrEn = 1'b1; bitWrIdx = 3'(idx); bitWrData = d;
    tick();
    bitWrEn = 1'b0;
  endtask

  task automatic settle();
    tmrPin = 4'h0; rxdPin = 1'b0;
    repeat (10) tick();
  endtask

  // Drives a w-cycle pulse on one source and counts high cycles of one output.
  task automatic pulseRun(input int srcCh, input bit onRxd, input int outCh,
                          input int w, output int cnt);
    cnt = 0;
    for (int i = 0; i < w + 14; i++) begin
      tick();
      if (filtOut[outCh]) cnt++;
      if (onRxd) rxdPin = (i < w);
      else       tmrPin[srcCh] = (i < w);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failCnt++;
      checkCnt++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    int cnt;
    int expv;
    repeat (4) tick();
    // R4 reset state
    check(ctrlRdData == 8'h00, "R4 reset register", ctrlRdData, 0);
    check(filtOut == 4'h0, "R4 reset outputs", filtOut, 0);
    rstN = 1'b1;
    tick();
    check(ctrlRdData == 8'h00 && ctrlRdSmall == 8'h00, "R4 after release", ctrlRdData, 0);

    // R5 / R8 byte write sweep over every value
    for (int v = 0; v < 256; v++) begin
      wrByte(8'(v));
      check(ctrlRdData == 8'(v & 8'h0F), "R5 byte write", ctrlRdData, v & 8'h0F);
      check(ctrlRdSmall == 8'(v & 8'h03), "R8 byte write small", ctrlRdSmall, v & 8'h03);
    end

    // R6 / R8 bit write sweep
    for (int s = 0; s < 2; s++) begin
      for (int idx = 0; idx < 8; idx++) begin
        for (int d = 0; d < 2; d++) begin
          logic [7:0] start;
          start = (s == 0) ? 8'h00 : 8'h0F;
          wrByte(start);
          wrBit(idx, d[0]);
          expv = (idx < 4) ? ((start & ~(8'd1 << idx)) | (8'(d) << idx)) : start;
          check(ctrlRdData == 8'(expv), "R6 bit write", ctrlRdData, expv);
          expv = (idx < 2) ? ((start & 8'h03 & ~(8'd1 << idx)) | (8'(d) << idx))
                           : (start & 8'h03);
          check(ctrlRdSmall == 8'(expv), "R8 bit write small", ctrlRdSmall, expv);
        end
      end
    end

    // R5 priority of byte over bit write
    byteWrEn = 1'b1; byteWrData = 8'h05; bitWrEn = 1'b1; bitWrIdx = 3'd1; bitWrData = 1'b1;
    tick();
    byteWrEn = 1'b0; bitWrEn = 1'b0;
    check(ctrlRdData == 8'h05, "R5 byte wins", ctrlRdData, 5);

    // R1 / R2 latency on channel 0
    for (int en = 0; en < 2; en++) begin
      wrByte(en[0] ? 8'h0F : 8'h00);
      settle();
      tmrPin[0] = 1'b1;
      for (int i = 1; i <= 4; i++) begin
        tick();
        if (i == 2 + en) check(filtOut[0] == 1'b0, en ? "R2 latency before" : "R1 latency before", filtOut[0], 0);
        if (i == 3 + en) check(filtOut[0] == 1'b1, en ? "R2 latency at" : "R1 latency at", filtOut[0], 1);
      end
    end

    // R1 / R2 pulse sweep on every channel
    for (int ch = 0; ch < 4; ch++) begin
      for (int en = 0; en < 2; en++) begin
        wrByte(en[0] ? 8'h0F : 8'h00);
        for (int w = 1; w <= 4; w++) begin
          settle();
          pulseRun(ch, 1'b0, ch, w, cnt);
          expv = (en == 1 && w == 1) ? 0 : w;
          check(cnt == expv, en ? "R2 pulse width" : "R1 pulse width", cnt, expv);
        end
      end
    end
    check(!smallLeak, "R8 absent outputs stay low", smallLeak, 0);

    // R7 channel 1 source select
    wrByte(8'h00);
    ch1SrcSel = 1'b1;
    settle();
    pulseRun(1, 1'b1, 1, 3, cnt);
    check(cnt == 3, "R7 rxd selected", cnt, 3);
    settle();
    pulseRun(1, 1'b0, 1, 3, cnt);
    check(cnt == 0, "R7 timer pin ignored", cnt, 0);
    ch1SrcSel = 1'b0;
    settle();
    pulseRun(1, 1'b1, 1, 3, cnt);
    check(cnt == 0, "R7 rxd ignored", cnt, 0);
    settle();
    pulseRun(1, 1'b0, 1, 3, cnt);
    check(cnt == 3, "R7 timer pin selected", cnt, 3);

    // R3 stall while operating-clock enable is low
    settle();
    opClkEn[0] = 1'b0;
    tmrPin[0] = 1'b1;
    begin
      bit moved;
      moved = 1'b0;
      for (int i = 0; i < 12; i++) begin
        tick();
        if (filtOut[0]) moved = 1'b1;
      end
      check(!moved, "R3 output held while stalled", moved, 0);
    end
    opClkEn[0] = 1'b1;
    for (int i = 1; i <= 3; i++) begin
      tick();
      if (i == 2) check(filtOut[0] == 1'b0, "R3 resume before", filtOut[0], 0);
      if (i == 3) check(filtOut[0] == 1'b1, "R3 resume at", filtOut[0], 1);
    end

    // R9 enable toggling with steady input gives no pulse
    repeat (4) tick();
    begin
      bit dropped;
      dropped = 1'b0;
      for (int i = 0; i < 10; i++) begin
        wrBit(0, i[0] ? 1'b0 : 1'b1);
        if (!filtOut[0]) dropped = 1'b1;
      end
      check(!dropped, "R9 no glitch on enable toggle", dropped, 0);
    end
    // R9 enable takes effect: filter on now rejects a one-cycle pulse
    wrBit(0, 1'b1);
    tmrPin[0] = 1'b0;
    repeat (6) tick();
    pulseRun(0, 1'b0, 0, 1, cnt);
    check(cnt == 0, "R9 new enable active", cnt, 0);
    wrBit(0, 1'b0);
    settle();
    pulseRun(0, 1'b0, 0, 1, cnt);
    check(cnt == 1, "R9 new disable active", cnt, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule